// File: doc/BRIEF.md
# Watermark-Interrupt Serial Port

This block is a byte-wide asynchronous serial port that sits on a simple 32-bit register bus. It is meant to be driven by a small console or terminal driver. Characters written to the transmit data register enter an 8-entry queue. A serializer sends them as frames with 8 data bits, no parity and one or two stop bits. A receiver samples the incoming line at the centre of each bit and places the complete characters in a second 8-entry queue. The bit period is `divisor + 1` clock cycles. The same divisor drives both directions.

The queue status is carried in bit 31 of the data registers. A read of the receive data register always removes a character if one is present. Software that must not disturb the queue polls the pending register instead. Each direction has a 3-bit level threshold. The receive side is pending while its queue holds more characters than the threshold. The transmit side is pending while its queue holds fewer characters than its threshold. One interrupt line is the OR of the pending bits that are enabled.

Top module: `wm_uart`

## Requirements
- R1: After reset, `tx_o` is 1, `irq_o` is 0, and the divisor, control and enable registers read 0.
- R2: A read of the transmit data register (offset 0x00) returns bit 31 = 1 exactly when the transmit queue holds 8 characters, and 0 otherwise. The result appears on `rdata_o` one cycle after the request.
- R3: A write to offset 0x00 queues `wdata_i[7:0]`. A write while the queue is full is dropped, and the queued characters go out in write order.
- R4: A read of offset 0x04 returns `{24'b0, char}` and removes that character. If the receive queue is empty, it returns 0x8000_0000 and changes nothing.
- R5: Each transmitted frame is one low start bit, then 8 data bits LSB first, then a high stop bit. Every bit lasts `divisor + 1` cycles. Offset 0x18 holds the divisor.
- R6: The receive pending bit is bit 1 of offset 0x14. It is 1 while the receive count is greater than the receive threshold (offset 0x0C bits 18:16). With a threshold of 0, one character is enough to set it.
- R7: The transmit pending bit is bit 0 of offset 0x14. It is 1 while the transmit count is less than the transmit threshold (offset 0x08 bits 18:16).
- R8: `irq_o` is the OR over both bits of (pending AND enable). The enable register is at offset 0x10 and uses the same bit positions as the pending register.
- R9: A character that completes while the receive queue is full is discarded. The 8 characters already queued are kept.
- R10: While offset 0x0C bit 0 (receive enable) is 0, frames on `rx_i` are not queued.
- R11: While offset 0x08 bit 0 (transmit enable) is 0, no new frame starts and `tx_o` stays high.
- R12: Offset 0x08 bit 1 set makes two stop bits, which gives a frame-to-frame spacing of 11 bit periods instead of 10 when characters are sent back to back.
- R13: A low pulse on `rx_i` shorter than half a bit period is not taken as a start bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access request, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 5 | Byte offset in the register window |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid the cycle after a read request |
| rx_i | input | 1 | Serial input, idle high |
| tx_o | output | 1 | Serial output, idle high |
| irq_o | output | 1 | Combined watermark interrupt |

## Verification
The queue assertions assume that the bus side never asks a full queue to accept a character or an empty queue to give one up. The register decode has to enforce this, so stimulus can include writes to a full transmit queue and reads of an empty receive queue. The receiver is assumed to see a line that is idle high between frames. The bench therefore drives `rx_i` only with whole frames at the programmed bit period, with loopback from `tx_o`, or with one deliberate short glitch. All serial stimulus uses a divisor of 3, so that every frame is a fixed 40 clock cycles and sample points fall well inside each bit.

// File: rtl/wm_uart_pkg.sv
package wm_uart_pkg;
  typedef enum logic [2:0] {
    REG_TXD = 3'd0,
    REG_RXD = 3'd1,
    REG_TXC = 3'd2,
    REG_RXC = 3'd3,
    REG_IE  = 3'd4,
    REG_IP  = 3'd5,
    REG_DIV = 3'd6
  } reg_idx_e;

  typedef enum logic [1:0] {
    S_IDLE,
    S_START,
    S_DATA,
    S_STOP
  } ser_state_e;

  localparam int unsigned WM_LSB = 16;
  localparam int unsigned WM_W   = 3;
endpackage

// File: rtl/wm_fifo.sv
module wm_fifo #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 8,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1),
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [W-1:0]     wdata_i,
  input  logic             pop_i,
  output logic [W-1:0]     rdata_o,
  output logic             full_o,
  output logic             empty_o,
  output logic [CNT_W-1:0] count_o
);
  logic [W-1:0]     mem_q [DEPTH];
  logic [PTR_W-1:0] wptr_q, rptr_q;
  logic [CNT_W-1:0] cnt_q;

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign count_o = cnt_q;
  assign rdata_o = mem_q[rptr_q];

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wptr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (push_i) wptr_q <= nxt(wptr_q);
      if (pop_i)  rptr_q <= nxt(rptr_q);
      if (push_i && !pop_i)      cnt_q <= cnt_q + CNT_W'(1);
      else if (pop_i && !push_i) cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o); // R3
  AST_NO_UNDERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o); // R4
endmodule

// File: rtl/wm_uart_tx.sv
module wm_uart_tx
  import wm_uart_pkg::*;
#(
  parameter int unsigned DIV_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             two_stop_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             empty_i,
  input  logic [7:0]       data_i,
  output logic             pop_o,
  output logic             tx_o
);
  ser_state_e       state_q;
  logic [DIV_W-1:0] cnt_q;
  logic [2:0]       bit_q;
  logic [7:0]       sh_q;
  logic             stop2_q, tx_q, tick, last_stop;

  assign tick      = (cnt_q == '0);
  assign last_stop = (state_q == S_STOP) && tick && !stop2_q;
  // back-to-back frames: load straight out of the final stop bit
  assign pop_o     = en_i && !empty_i && ((state_q == S_IDLE) || last_stop);
  assign tx_o      = tx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      cnt_q   <= '0;
      bit_q   <= '0;
      sh_q    <= '0;
      stop2_q <= 1'b0;
      tx_q    <= 1'b1;
    end else if (pop_o) begin
      state_q <= S_START;
      cnt_q   <= div_i;
      sh_q    <= data_i;
      bit_q   <= '0;
      tx_q    <= 1'b0;
    end else begin
      unique case (state_q)
        S_IDLE: tx_q <= 1'b1;
        S_START: begin
          if (tick) begin
            state_q <= S_DATA;
            cnt_q   <= div_i;
            tx_q    <= sh_q[0];
          end else cnt_q <= cnt_q - DIV_W'(1);
        end
        S_DATA: begin
          if (tick) begin
            cnt_q <= div_i;
            if (bit_q == 3'd7) begin
              state_q <= S_STOP;
              stop2_q <= two_stop_i;
              tx_q    <= 1'b1;
            end else begin
              bit_q <= bit_q + 3'd1;
              sh_q  <= sh_q >> 1;
              tx_q  <= sh_q[1];
            end
          end else cnt_q <= cnt_q - DIV_W'(1);
        end
        S_STOP: begin
          if (tick) begin
            if (stop2_q) begin
              stop2_q <= 1'b0;
              cnt_q   <= div_i;
            end else state_q <= S_IDLE;
          end else cnt_q <= cnt_q - DIV_W'(1);
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  AST_TX_START_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_o |=> !tx_o); // R5
  AST_TX_STOP_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_STOP) |-> tx_o); // R5
  AST_TX_IDLE_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == S_IDLE) && !en_i) |=> tx_o); // R11
endmodule

// File: rtl/wm_uart_rx.sv
module wm_uart_rx
  import wm_uart_pkg::*;
#(
  parameter int unsigned DIV_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             rx_i,
  input  logic             full_i,
  output logic             push_o,
  output logic [7:0]       data_o
);
  ser_state_e       state_q;
  logic [DIV_W-1:0] cnt_q;
  logic [2:0]       bit_q;
  logic [7:0]       sh_q;
  logic             s1_q, s2_q, tick;

  assign tick   = (cnt_q == '0);
  assign push_o = (state_q == S_STOP) && tick && s2_q && !full_i;
  assign data_o = sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= 1'b1;
      s2_q <= 1'b1;
    end else begin
      s1_q <= rx_i;
      s2_q <= s1_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      cnt_q   <= '0;
      bit_q   <= '0;
      sh_q    <= '0;
    end else begin
      unique case (state_q)
        S_IDLE: begin
          if (en_i && !s2_q) begin
            state_q <= S_START;
            cnt_q   <= div_i >> 1;
          end
        end
        S_START: begin
          if (tick) begin
            // line must still be low at mid-bit
            if (!s2_q) begin
              state_q <= S_DATA;
              cnt_q   <= div_i;
              bit_q   <= '0;
            end else state_q <= S_IDLE;
          end else cnt_q <= cnt_q - DIV_W'(1);
        end
        S_DATA: begin
          if (tick) begin
            sh_q  <= {s2_q, sh_q[7:1]};
            cnt_q <= div_i;
            if (bit_q == 3'd7) state_q <= S_STOP;
            else bit_q <= bit_q + 3'd1;
          end else cnt_q <= cnt_q - DIV_W'(1);
        end
        S_STOP: begin
          if (tick) state_q <= S_IDLE;
          else cnt_q <= cnt_q - DIV_W'(1);
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  AST_RX_GLITCH_REJECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == S_START) && tick && s2_q) |=> (state_q == S_IDLE)); // R13
  AST_RX_FULL_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_i |-> !push_o); // R9
endmodule

// File: rtl/wm_uart.sv
module wm_uart
  import wm_uart_pkg::*;
#(
  parameter int unsigned DIV_W      = 16,
  parameter int unsigned FIFO_DEPTH = 8,
  localparam int unsigned CNT_W     = $clog2(FIFO_DEPTH + 1)
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_i,
  input  logic        we_i,
  input  logic [4:0]  addr_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  input  logic        rx_i,
  output logic        tx_o,
  output logic        irq_o
);
  reg_idx_e         idx;
  logic             wr, rd;
  logic             txen_q, nstop_q, rxen_q;
  logic [WM_W-1:0]  txwm_q, rxwm_q;
  logic [1:0]       ie_q, ip;
  logic [DIV_W-1:0] div_q;
  logic [31:0]      rdata_q, rd_val;

  logic             tx_push, tx_pop, tx_full, tx_empty;
  logic [7:0]       tx_data;
  logic [CNT_W-1:0] tx_cnt;
  logic             rx_push, rx_pop, rx_full, rx_empty;
  logic [7:0]       rx_wdata, rx_rdata;
  logic [CNT_W-1:0] rx_cnt;

  assign idx     = reg_idx_e'(addr_i[4:2]);
  assign wr      = req_i && we_i;
  assign rd      = req_i && !we_i;
  assign tx_push = wr && (idx == REG_TXD) && !tx_full;
  assign rx_pop  = rd && (idx == REG_RXD) && !rx_empty;

  assign ip[0]   = tx_cnt < CNT_W'(txwm_q);
  assign ip[1]   = rx_cnt > CNT_W'(rxwm_q);
  assign irq_o   = |(ip & ie_q);
  assign rdata_o = rdata_q;

  always_comb begin
    rd_val = '0;
    unique case (idx)
      REG_TXD: rd_val = {tx_full, 31'b0};
      REG_RXD: rd_val = rx_empty ? 32'h8000_0000 : {24'b0, rx_rdata};
      REG_TXC: rd_val = {13'b0, txwm_q, 14'b0, nstop_q, txen_q};
      REG_RXC: rd_val = {13'b0, rxwm_q, 15'b0, rxen_q};
      REG_IE:  rd_val = {30'b0, ie_q};
      REG_IP:  rd_val = {30'b0, ip};
      REG_DIV: rd_val = {{(32-DIV_W){1'b0}}, div_q};
      default: rd_val = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      txen_q  <= 1'b0;
      nstop_q <= 1'b0;
      txwm_q  <= '0;
      rxen_q  <= 1'b0;
      rxwm_q  <= '0;
      ie_q    <= '0;
      div_q   <= '0;
      rdata_q <= '0;
    end else begin
      if (rd) rdata_q <= rd_val;
      if (wr) begin
        unique case (idx)
          REG_TXC: begin
            txen_q  <= wdata_i[0];
            nstop_q <= wdata_i[1];
            txwm_q  <= wdata_i[WM_LSB +: WM_W];
          end
          REG_RXC: begin
            rxen_q <= wdata_i[0];
            rxwm_q <= wdata_i[WM_LSB +: WM_W];
          end
          REG_IE:  ie_q  <= wdata_i[1:0];
          REG_DIV: div_q <= wdata_i[DIV_W-1:0];
          default: ;
        endcase
      end
    end
  end

  wm_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) u_tx_fifo (
    .clk_i, .rst_ni,
    .push_i(tx_push), .wdata_i(wdata_i[7:0]),
    .pop_i(tx_pop), .rdata_o(tx_data),
    .full_o(tx_full), .empty_o(tx_empty), .count_o(tx_cnt)
  );

  wm_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) u_rx_fifo (
    .clk_i, .rst_ni,
    .push_i(rx_push), .wdata_i(rx_wdata),
    .pop_i(rx_pop), .rdata_o(rx_rdata),
    .full_o(rx_full), .empty_o(rx_empty), .count_o(rx_cnt)
  );

  wm_uart_tx #(.DIV_W(DIV_W)) u_tx (
    .clk_i, .rst_ni,
    .en_i(txen_q), .two_stop_i(nstop_q), .div_i(div_q),
    .empty_i(tx_empty), .data_i(tx_data),
    .pop_o(tx_pop), .tx_o(tx_o)
  );

  wm_uart_rx #(.DIV_W(DIV_W)) u_rx (
    .clk_i, .rst_ni,
    .en_i(rxen_q), .div_i(div_q), .rx_i(rx_i),
    .full_i(rx_full), .push_o(rx_push), .data_o(rx_wdata)
  );

  AST_RX_EMPTY_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && (idx == REG_RXD) && rx_empty) |=> rdata_o[31]); // R4
  AST_TX_FULL_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && (idx == REG_TXD)) |=> (rdata_o[31] == $past(tx_full))); // R2
  AST_IRQ_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ie_q == 2'b00) |-> !irq_o); // R8
endmodule

// File: tb/tb_wm_uart.sv
module tb_wm_uart;
  localparam int CLK_PERIOD = 10;
  localparam int BIT_CYC    = 4;

  localparam logic [7:0] LOOP_VEC [6] = '{8'h00, 8'hFF, 8'hA5, 8'h5A, 8'h01, 8'h80};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rx_drv = 1'b1, loop_en = 1'b0;
  logic        tx, irq, rx_line;
  int          n_run = 0, n_fail = 0;
  int          cyc = 0;

  assign rx_line = loop_en ? tx : rx_drv;

  wm_uart dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .rx_i(rx_line), .tx_o(tx), .irq_o(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [4:0] a, input logic [31:0] d);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic bus_rd(input logic [4:0] a, output logic [31:0] d);
    req = 1'b1; we = 1'b0; addr = a;
    @(negedge clk);
    d = rdata;
    req = 1'b0;
  endtask

  task automatic send_rx(input logic [7:0] b);
    rx_drv = 1'b0;
    repeat (BIT_CYC) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rx_drv = b[i];
      repeat (BIT_CYC) @(negedge clk);
    end
    rx_drv = 1'b1;
    repeat (2*BIT_CYC) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog R1 actual=timeout expected=completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] r;
    logic [9:0]  frame;
    int          t0, t1, lows;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 tx idle", {31'b0, tx}, 32'd1);
    check("R1 irq", {31'b0, irq}, 32'd0);
    bus_rd(5'h18, r); check("R1 divisor", r, 32'd0);
    bus_rd(5'h08, r); check("R1 txctrl", r, 32'd0);
    bus_rd(5'h10, r); check("R1 ie", r, 32'd0);
    bus_rd(5'h04, r); check("R4 empty read at reset", r, 32'h8000_0000);

    bus_wr(5'h18, 32'd3);
    bus_rd(5'h18, r); check("R5 divisor readback", r, 32'd3);

    // loopback table: R5 framing / R6 single-char pending
    loop_en = 1'b1;
    bus_wr(5'h0C, 32'h1);
    bus_wr(5'h08, 32'h1);
    for (int k = 0; k < 6; k++) begin
      bus_wr(5'h00, {24'b0, LOOP_VEC[k]});
      repeat (60) @(negedge clk);
      bus_rd(5'h14, r); check("R6 rx pending after one char", r, 32'd2);
      bus_rd(5'h04, r); check("R5 loopback data", r, {24'b0, LOOP_VEC[k]});
    end
    bus_rd(5'h14, r); check("R6 rx pending clear", r, 32'd0);

    // R5 waveform of 0xA5 with bit period 4
    bus_wr(5'h00, 32'hA5);
    @(negedge tx);
    repeat (2) @(negedge clk);
    frame[0] = tx;
    for (int i = 1; i < 10; i++) begin
      repeat (BIT_CYC) @(negedge clk);
      frame[i] = tx;
    end
    check("R5 frame bits", {22'b0, frame}, {22'b0, 1'b1, 8'hA5, 1'b0});
    repeat (20) @(negedge clk);
    bus_rd(5'h04, r); check("R5 frame received", r, 32'hA5);

    // R12 stop-bit spacing, rx disabled (R10)
    bus_wr(5'h0C, 32'h0);
    bus_wr(5'h08, 32'h0);
    bus_wr(5'h00, 32'hFF);
    bus_wr(5'h00, 32'hFF);
    bus_wr(5'h08, 32'h1);
    @(negedge tx); t0 = cyc;
    @(negedge tx); t1 = cyc;
    check("R12 one stop spacing", t1 - t0, 32'd40);
    repeat (60) @(negedge clk);
    bus_wr(5'h08, 32'h0);
    bus_wr(5'h00, 32'hFF);
    bus_wr(5'h00, 32'hFF);
    bus_wr(5'h08, 32'h3);
    @(negedge tx); t0 = cyc;
    @(negedge tx); t1 = cyc;
    check("R12 two stop spacing", t1 - t0, 32'd44);
    repeat (60) @(negedge clk);
    bus_rd(5'h04, r); check("R10 rx disabled nothing queued", r, 32'h8000_0000);

    // R11 tx disabled holds high
    bus_wr(5'h08, 32'h0);
    bus_wr(5'h00, 32'h11);
    lows = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (!tx) lows++;
    end
    check("R11 tx held high", lows, 32'd0);

    // R7 tx watermark (count 1, threshold 2)
    bus_wr(5'h08, 32'h0002_0000);
    bus_rd(5'h14, r); check("R7 tx pending 1<2", r & 32'h1, 32'h1);
    bus_wr(5'h00, 32'h22);
    bus_rd(5'h14, r); check("R7 tx not pending 2<2", r & 32'h1, 32'h0);

    // R8 irq gating (threshold 3 -> pending)
    bus_wr(5'h08, 32'h0003_0000);
    @(negedge clk);
    check("R8 irq masked", {31'b0, irq}, 32'd0);
    bus_wr(5'h10, 32'h1);
    check("R8 irq enabled", {31'b0, irq}, 32'd1);
    bus_wr(5'h10, 32'h0);
    check("R8 irq masked again", {31'b0, irq}, 32'd0);

    // R2/R3 fill, overflow, drain
    for (int i = 0; i < 5; i++) bus_wr(5'h00, 32'h30 + i);
    bus_rd(5'h00, r); check("R2 not full at 7", r, 32'h0);
    bus_wr(5'h00, 32'h35);
    bus_rd(5'h00, r); check("R2 full at 8", r, 32'h8000_0000);
    bus_wr(5'h00, 32'hEE);
    bus_wr(5'h0C, 32'h1);
    bus_wr(5'h08, 32'h1);
    repeat (400) @(negedge clk);
    bus_rd(5'h04, r); check("R3 order 0", r, 32'h11);
    bus_rd(5'h04, r); check("R3 order 1", r, 32'h22);
    for (int i = 0; i < 6; i++) begin
      bus_rd(5'h04, r); check("R3 order n", r, 32'h30 + i);
    end
    bus_rd(5'h04, r); check("R3 full write dropped", r, 32'h8000_0000);

    // R6 threshold 2, then R9 overflow via driven line
    loop_en = 1'b0;
    bus_wr(5'h0C, 32'h0002_0001);
    send_rx(8'h40);
    send_rx(8'h41);
    bus_rd(5'h14, r); check("R6 rx 2 not > 2", r & 32'h2, 32'h0);
    send_rx(8'h42);
    bus_rd(5'h14, r); check("R6 rx 3 > 2", r & 32'h2, 32'h2);
    for (int i = 3; i < 9; i++) send_rx(8'h40 + 8'(i));
    for (int i = 0; i < 8; i++) begin
      bus_rd(5'h04, r); check("R9 kept data", r, 32'h40 + i);
    end
    bus_rd(5'h04, r); check("R9 ninth discarded", r, 32'h8000_0000);

    // R13 short glitch
    rx_drv = 1'b0;
    @(negedge clk);
    rx_drv = 1'b1;
    repeat (60) @(negedge clk);
    bus_rd(5'h04, r); check("R13 glitch ignored", r, 32'h8000_0000);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule